// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the device-side end of a four-byte serial programming link. An external programmer drives a serial clock, a data line into the device and an active-high request that puts the device in programming mode. The block samples these lines with the faster CPU clock, filters out clock phases that are too short, shifts each instruction in most significant bit first and returns a byte stream on its serial output. Flash (256 words of 16 bits, in pages of 32 words) and a 64-byte EEPROM are modelled as register arrays inside the block.

A session opens with an enable instruction. Only when its second byte comes back during the third byte does the programmer know the link is aligned, and only after the enable frame completes does the block act on other instructions. Flash is filled through a page buffer, loaded byte by byte with the low byte of each word first, then committed to a page. EEPROM bytes are written directly, each write replacing the old contents. Commits, EEPROM writes and chip erase hold a busy flag for a fixed number of cycles, which the programmer can poll.

Top module: `isp_target`

## Requirements
- R1: Every instruction is 32 bits as four bytes, MSB first. A data bit is taken on each filtered rising edge of `sck`, and the bit counter moves only on those edges.
- R2: `miso` changes only on filtered falling edges of `sck`. During bytes 2 and 3 of a frame it returns the byte received just before, and during byte 1 it sends 0x00.
- R3: A frame with byte 1 = 0xAC and byte 2 = 0x53 sets `in_sync` at the end of the frame. Its 0x53 is returned during the third byte.
- R4: Before `in_sync` is set, every instruction other than the enable frame is ignored. Reads return 0x00 in the fourth byte.
- R5: Byte 1 = 0x40 stores byte 4 as the low byte, and 0x48 stores it as the high byte, of the page-buffer word chosen by byte 3 bits [4:0].
- R6: A high-byte load whose word has not had a low byte since the last commit is not stored and sets the sticky `order_err`.
- R7: Byte 1 = 0x4C copies the whole page buffer into the flash page chosen by byte 3 bits [7:5], then clears the low-byte record of every word. Other pages stay unchanged.
- R8: Byte 1 = 0x20 (low) or 0x28 (high) returns, in the fourth byte, that byte of the flash word at address byte 3.
- R9: Byte 1 = 0xC0 writes byte 4 into the EEPROM cell at byte 3 bits [5:0], replacing the old value without an erase first. Byte 1 = 0xA0 reads that cell back in the fourth byte.
- R10: Byte 1 = 0xAC with byte 2 = 0x80 sets every flash word to 0xFFFF and every EEPROM byte to 0xFF. Both arrays also hold these values after reset.
- R11: A commit, EEPROM write or erase raises `busy` for BUSY_CYCLES clocks. Byte 1 = 0xF0 returns `busy` in bit 0 of the fourth byte. Load, commit, write and erase frames arriving while busy are ignored.
- R12: While `prog_req` is low, the bit and byte counters are held at zero and `in_sync`, `order_err` and `miso` are cleared.
- R13: A `sck` level that lasts fewer than 2 CPU clocks, or fewer than 3 when `fast_clk` is set, does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_req | input | 1 | Programming-mode request, active high, asynchronous |
| fast_clk | input | 1 | Selects the longer minimum phase for a fast CPU clock |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| busy | output | 1 | A write or erase is in progress |
| in_sync | output | 1 | An enable frame has been received |
| order_err | output | 1 | Sticky page-buffer ordering error |

## Verification
On every cycle, the assertions check the following: `miso` moves only on a filtered falling edge and the bit counter only on a filtered rising edge, and accepted edges follow at least two cycles of a steady level. Sync, busy and ordering errors can start only at a frame boundary, nothing starts busy before sync, and dropping the request clears the session state. Only the bench's frame sequences can show what ends up where: the echo contents, page and word addressing, low-before-high ordering, auto-erase overwrite, chip erase, busy polling, instructions ignored while busy, recovery after a dropped request, and rejection of short clock glitches.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] KEY_SYNC   = 8'h53;
  localparam logic [7:0] KEY_ERASE  = 8'h80;
  localparam logic [7:0] OP_LOAD_LO = 8'h40;
  localparam logic [7:0] OP_LOAD_HI = 8'h48;
  localparam logic [7:0] OP_COMMIT  = 8'h4C;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_EE_WR   = 8'hC0;
  localparam logic [7:0] OP_EE_RD   = 8'hA0;
  localparam logic [7:0] OP_POLL    = 8'hF0;
endpackage

// File: rtl/isp_sampler.sv
module isp_sampler #(
  parameter int MIN_SLOW = 2,
  parameter int MIN_FAST = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic mosi,
  input  logic req,
  input  logic fast,
  output logic sck_s,
  output logic req_s,
  output logic rise_evt,
  output logic fall_evt,
  output logic mosi_bit
);
  localparam int CW = $clog2(MIN_FAST) + 1;
  localparam logic [CW-1:0] LIM_SLOW = CW'(MIN_SLOW - 1);
  localparam logic [CW-1:0] LIM_FAST = CW'(MIN_FAST - 1);

  logic sck_m, mosi_m, mosi_s, req_m, filt_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic filt_nx, rise_nx, fall_nx, bit_nx, acc, diff;
  logic [CW-1:0] lim;

  always_comb begin
    lim     = fast ? LIM_FAST : LIM_SLOW;
    diff    = (sck_s != filt_q);
    acc     = diff && (cnt_q == lim);
    cnt_nx  = (diff && !acc) ? cnt_q + 1'b1 : '0;
    filt_nx = acc ? sck_s : filt_q;
    rise_nx = acc && sck_s;
    fall_nx = acc && !sck_s;
    bit_nx  = acc ? mosi_s : mosi_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= 1'b0; sck_s <= 1'b0;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
      req_m <= 1'b0; req_s <= 1'b0;
      filt_q <= 1'b0; cnt_q <= '0;
      rise_evt <= 1'b0; fall_evt <= 1'b0; mosi_bit <= 1'b0;
    end else begin
      sck_m <= sck;   sck_s <= sck_m;
      mosi_m <= mosi; mosi_s <= mosi_m;
      req_m <= req;   req_s <= req_m;
      filt_q <= filt_nx; cnt_q <= cnt_nx;
      rise_evt <= rise_nx; fall_evt <= fall_nx; mosi_bit <= bit_nx;
    end
  end
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       rise_evt,
  input  logic       fall_evt,
  input  logic       mosi_bit,
  input  logic [7:0] resp,
  output logic       done,
  output logic [7:0] byte_val,
  output logic [1:0] byte_idx,
  output logic [2:0] bitcnt,
  output logic       miso
);
  logic [7:0] rx_q, rx_nx, tx_q, tx_nx, val_nx;
  logic [2:0] bit_nx;
  logic [1:0] idx_q, idx_nx, didx_nx;
  logic       done_nx;

  always_comb begin
    rx_nx = rx_q; tx_nx = tx_q; bit_nx = bitcnt; idx_nx = idx_q;
    val_nx = byte_val; didx_nx = byte_idx; done_nx = 1'b0;
    if (!active) begin
      rx_nx = '0; tx_nx = '0; bit_nx = '0; idx_nx = '0;
    end else begin
      if (rise_evt) begin
        rx_nx  = {rx_q[6:0], mosi_bit};
        bit_nx = bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          done_nx = 1'b1;
          val_nx  = {rx_q[6:0], mosi_bit};
          didx_nx = idx_q;
          idx_nx  = idx_q + 2'd1;
        end
      end
      if (fall_evt)
        tx_nx = (bitcnt == 3'd0) ? resp : {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '0; tx_q <= '0; bitcnt <= '0; idx_q <= '0;
      done <= 1'b0; byte_val <= '0; byte_idx <= '0;
    end else begin
      rx_q <= rx_nx; tx_q <= tx_nx; bitcnt <= bit_nx; idx_q <= idx_nx;
      done <= done_nx; byte_val <= val_nx; byte_idx <= didx_nx;
    end
  end

  assign miso = tx_q[7];
endmodule

// File: rtl/isp_core.sv
module isp_core
  import isp_pkg::*;
#(
  parameter int FLASH_WORDS = 256,
  parameter int PAGE_WORDS  = 32,
  parameter int EE_BYTES    = 64,
  parameter int BUSY_CYCLES = 1200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic       done,
  input  logic [7:0] byte_val,
  input  logic [1:0] byte_idx,
  output logic [7:0] resp,
  output logic       busy,
  output logic       in_sync,
  output logic       order_err,
  output logic       frame_done
);
  localparam int FAW = $clog2(FLASH_WORDS);
  localparam int PAW = $clog2(PAGE_WORDS);
  localparam int PGW = FAW - PAW;
  localparam int EAW = $clog2(EE_BYTES);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  logic [7:0]  op_q, key_q, adr_q, op_nx, key_nx, adr_nx, resp_nx, rd_data;
  logic        sync_nx, oerr_nx;
  logic [BCW-1:0] bcnt_q, bcnt_nx;
  logic [PAGE_WORDS-1:0] lo_seen_q, lo_seen_nx;
  logic [15:0] pbuf_q  [PAGE_WORDS];
  logic [15:0] flash_q [FLASH_WORDS];
  logic [7:0]  ee_q    [EE_BYTES];
  logic        exec, do_lo, do_hi, bad_hi, do_commit, do_ee, do_erase;
  logic [PAW-1:0] word;
  logic [PGW-1:0] page;

  assign busy = (bcnt_q != '0);

  always_comb begin
    frame_done = done && (byte_idx == 2'd3);
    exec      = frame_done && in_sync && !busy;
    word      = adr_q[PAW-1:0];
    page      = adr_q[FAW-1:PAW];
    do_lo     = exec && (op_q == OP_LOAD_LO);
    do_hi     = exec && (op_q == OP_LOAD_HI) && lo_seen_q[word];
    bad_hi    = exec && (op_q == OP_LOAD_HI) && !lo_seen_q[word];
    do_commit = exec && (op_q == OP_COMMIT);
    do_ee     = exec && (op_q == OP_EE_WR);
    do_erase  = exec && (op_q == OP_ENABLE) && (key_q == KEY_ERASE);

    rd_data = 8'h00;
    if (in_sync) begin
      case (op_q)
        OP_RD_LO: rd_data = flash_q[byte_val[FAW-1:0]][7:0];
        OP_RD_HI: rd_data = flash_q[byte_val[FAW-1:0]][15:8];
        OP_EE_RD: rd_data = ee_q[byte_val[EAW-1:0]];
        OP_POLL:  rd_data = {7'd0, busy};
        default:  rd_data = 8'h00;
      endcase
    end

    op_nx = op_q; key_nx = key_q; adr_nx = adr_q; resp_nx = resp;
    if (done) begin
      case (byte_idx)
        2'd0: begin op_nx  = byte_val; resp_nx = byte_val; end
        2'd1: begin key_nx = byte_val; resp_nx = byte_val; end
        2'd2: begin adr_nx = byte_val; resp_nx = rd_data;  end
        default: resp_nx = 8'h00;
      endcase
    end

    sync_nx = in_sync;
    if (!active) sync_nx = 1'b0;
    else if (frame_done && op_q == OP_ENABLE && key_q == KEY_SYNC) sync_nx = 1'b1;

    oerr_nx = order_err;
    if (!active) oerr_nx = 1'b0;
    else if (bad_hi) oerr_nx = 1'b1;

    if (do_commit || do_ee || do_erase) bcnt_nx = BCW'(BUSY_CYCLES);
    else if (busy) bcnt_nx = bcnt_q - 1'b1;
    else bcnt_nx = bcnt_q;

    lo_seen_nx = lo_seen_q;
    if (do_commit) lo_seen_nx = '0;
    else if (do_lo) lo_seen_nx[word] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; key_q <= '0; adr_q <= '0; resp <= '0;
      in_sync <= 1'b0; order_err <= 1'b0; bcnt_q <= '0; lo_seen_q <= '0;
    end else begin
      op_q <= op_nx; key_q <= key_nx; adr_q <= adr_nx; resp <= resp_nx;
      in_sync <= sync_nx; order_err <= oerr_nx; bcnt_q <= bcnt_nx;
      lo_seen_q <= lo_seen_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < PAGE_WORDS; w++) pbuf_q[w] <= 16'hFFFF;
    end else begin
      if (do_lo) pbuf_q[word][7:0]  <= byte_val;
      if (do_hi) pbuf_q[word][15:8] <= byte_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < FLASH_WORDS; a++) flash_q[a] <= 16'hFFFF;
    end else if (do_erase) begin
      for (int a = 0; a < FLASH_WORDS; a++) flash_q[a] <= 16'hFFFF;
    end else if (do_commit) begin
      for (int w = 0; w < PAGE_WORDS; w++) flash_q[{page, PAW'(w)}] <= pbuf_q[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < EE_BYTES; a++) ee_q[a] <= 8'hFF;
    end else if (do_erase) begin
      for (int a = 0; a < EE_BYTES; a++) ee_q[a] <= 8'hFF;
    end else if (do_ee) begin
      ee_q[adr_q[EAW-1:0]] <= byte_val;
    end
  end
endmodule

// File: rtl/isp_target.sv
module isp_target #(
  parameter int FLASH_WORDS = 256,
  parameter int PAGE_WORDS  = 32,
  parameter int EE_BYTES    = 64,
  parameter int BUSY_CYCLES = 1200,
  parameter int MIN_SLOW    = 2,
  parameter int MIN_FAST    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_req,
  input  logic fast_clk,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic busy,
  output logic in_sync,
  output logic order_err
);
  logic       sck_s, req_s, rise_evt, fall_evt, mosi_bit;
  logic       done, frame_done;
  logic [7:0] byte_val, resp;
  logic [1:0] byte_idx;
  logic [2:0] bitcnt;

  isp_sampler #(.MIN_SLOW(MIN_SLOW), .MIN_FAST(MIN_FAST)) u_smp (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .req(prog_req),
    .fast(fast_clk), .sck_s(sck_s), .req_s(req_s), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .mosi_bit(mosi_bit)
  );

  isp_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .active(req_s), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .mosi_bit(mosi_bit), .resp(resp), .done(done),
    .byte_val(byte_val), .byte_idx(byte_idx), .bitcnt(bitcnt), .miso(miso)
  );

  isp_core #(
    .FLASH_WORDS(FLASH_WORDS), .PAGE_WORDS(PAGE_WORDS),
    .EE_BYTES(EE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .active(req_s), .done(done),
    .byte_val(byte_val), .byte_idx(byte_idx), .resp(resp), .busy(busy),
    .in_sync(in_sync), .order_err(order_err), .frame_done(frame_done)
  );
endmodule

// File: rtl/isp_target_checker.sv
module isp_target_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_s,
  input logic       sck_s,
  input logic       rise_evt,
  input logic       fall_evt,
  input logic       frame_done,
  input logic [2:0] bitcnt,
  input logic       miso,
  input logic       busy,
  input logic       in_sync,
  input logic       order_err
);
  p_edges_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_evt && fall_evt));

  p_bitcnt_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_s && !rise_evt) |=> $stable(bitcnt));

  p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_s && !fall_evt) |=> $stable(miso));

  p_sync_at_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(frame_done));

  p_no_write_presync_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sync |=> !$rose(busy));

  p_order_at_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(order_err) |-> ($past(frame_done) && $past(in_sync)));

  p_busy_at_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(frame_done));

  p_drop_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_s |=> (!in_sync && !order_err && bitcnt == 3'd0 && !miso));

  p_min_phase_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> ($past(sck_s) && $past(sck_s, 2)));
endmodule

bind isp_target isp_target_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_s(req_s), .sck_s(sck_s),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .frame_done(frame_done),
  .bitcnt(bitcnt), .miso(miso), .busy(busy), .in_sync(in_sync),
  .order_err(order_err)
);

// File: tb/isp_target_test.sv
module isp_target_test;
  localparam int H = 12;
  localparam int NV = 20;
  // {command[31:0], expected fourth response byte, wait-for-idle flag}
  localparam logic [40:0] VEC [NV] = '{
    {32'h20_00_05_00, 8'h00, 1'b0},
    {32'hC0_00_03_5A, 8'h00, 1'b0},
    {32'hAC_53_00_00, 8'h00, 1'b0},
    {32'hA0_00_03_00, 8'hFF, 1'b0},
    {32'h40_00_42_34, 8'h00, 1'b0},
    {32'h48_00_42_12, 8'h00, 1'b0},
    {32'h48_00_47_99, 8'h00, 1'b0},
    {32'h4C_00_40_00, 8'h00, 1'b0},
    {32'hF0_00_00_00, 8'h01, 1'b1},
    {32'h20_00_42_00, 8'h34, 1'b0},
    {32'h28_00_42_00, 8'h12, 1'b0},
    {32'h28_00_47_00, 8'hFF, 1'b0},
    {32'h20_00_02_00, 8'hFF, 1'b0},
    {32'hC0_00_03_5A, 8'h00, 1'b1},
    {32'hA0_00_03_00, 8'h5A, 1'b0},
    {32'hC0_00_03_A5, 8'h00, 1'b1},
    {32'hA0_00_03_00, 8'hA5, 1'b0},
    {32'hAC_80_00_00, 8'h00, 1'b1},
    {32'hA0_00_03_00, 8'hFF, 1'b0},
    {32'h20_00_42_00, 8'hFF, 1'b0}
  };

  logic clk, rst_n, prog_req, fast_clk, sck, mosi;
  logic miso, busy, in_sync, order_err;
  int checks, errors;
  bit finished;

  isp_target uut (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .fast_clk(fast_clk),
    .sck(sck), .mosi(mosi), .miso(miso), .busy(busy), .in_sync(in_sync),
    .order_err(order_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] cmd, input int n, output logic [31:0] rsp);
    rsp = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mosi = cmd[31-i];
      repeat (H) @(negedge clk);
      rsp[31-i] = miso;
      sck = 1'b1;
      repeat (H) @(negedge clk);
      sck = 1'b0;
    end
    repeat (H) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int k = 0; k < 12; k++) begin
      send_bits(32'hF0_00_00_00, 32, r);
      if (r[0] == 1'b0) break;
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 3:    return "R4";
      8:       return "R11";
      9, 10:   return "R8";
      11:      return "R6";
      12:      return "R7";
      14, 16:  return "R9";
      18, 19:  return "R10";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; prog_req = 1'b0; fast_clk = 1'b0; sck = 1'b0; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12 reset miso", {7'd0, miso}, 8'h00);
    check("R11 reset busy", {7'd0, busy}, 8'h00);
    check("R3 reset sync", {7'd0, in_sync}, 8'h00);
    check("R6 reset order_err", {7'd0, order_err}, 8'h00);
    prog_req = 1'b1;
    repeat (10) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      send_bits(VEC[i][40:9], 32, r);
      check("R1 echo of byte 1", r[23:16], VEC[i][40:33]);
      check("R2 echo of byte 2", r[15:8], VEC[i][32:25]);
      check(tag_of(i), r[7:0], VEC[i][8:1]);
      if (i == 2) check("R3 sync set", {7'd0, in_sync}, 8'h01);
      if (VEC[i][0]) wait_idle();
    end
    check("R6 order_err sticky", {7'd0, order_err}, 8'h01);

    // Writes while busy are ignored
    send_bits(32'hC0_00_05_11, 32, r);
    send_bits(32'hC0_00_05_22, 32, r);
    wait_idle();
    send_bits(32'hA0_00_05_00, 32, r);
    check("R11 write during busy ignored", r[7:0], 8'h11);

    // Short clock glitches are rejected
    @(negedge clk); sck = 1'b1; @(negedge clk); sck = 1'b0;
    repeat (H) @(negedge clk);
    send_bits(32'hA0_00_05_00, 32, r);
    check("R13 one-cycle glitch ignored", r[7:0], 8'h11);
    fast_clk = 1'b1;
    @(negedge clk); sck = 1'b1; repeat (2) @(negedge clk); sck = 1'b0;
    repeat (H) @(negedge clk);
    send_bits(32'hA0_00_05_00, 32, r);
    check("R13 two-cycle glitch ignored in fast mode", r[7:0], 8'h11);
    fast_clk = 1'b0;

    // Dropping the request mid-frame
    send_bits(32'hA0_00_05_00, 12, r);
    prog_req = 1'b0;
    repeat (6) @(negedge clk);
    check("R12 sync cleared", {7'd0, in_sync}, 8'h00);
    check("R12 order_err cleared", {7'd0, order_err}, 8'h00);
    check("R12 miso cleared", {7'd0, miso}, 8'h00);
    prog_req = 1'b1;
    repeat (6) @(negedge clk);
    send_bits(32'hA0_00_05_00, 32, r);
    check("R12 realigned, R4 read before sync", r[7:0], 8'h00);
    check("R12 realigned echo", r[23:16], 8'hA0);
    send_bits(32'hAC_53_00_00, 32, r);
    check("R3 resync echo", r[15:8], 8'h53);
    send_bits(32'hA0_00_05_00, 32, r);
    check("R9 data kept after resync", r[7:0], 8'h11);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule